// File: doc/BRIEF.md
# Indexed Block Configuration Target for a Two-Wire Serial Bus

This block is a target on an SMBus/I2C two-wire bus. It holds a fourteen-byte configuration register file. A host reaches that file with indexed block transfers. Every write carries a starting index and then a byte count, followed by that many data bytes. A read begins with a write-direction header that sets the index. A repeated start then turns the bus around, and the target answers with the stored byte count before the data. The block runs on a fast system clock and oversamples SCL and SDA. It pulls SDA low through an open-drain enable and never stretches the clock.

The whole register file is driven as a parallel bus, so that neighbouring logic can read its settings directly. One five-bit frequency-select output is a mode switch. Bit 7 of index 0 selects whether that output comes from strap pins captured during reset or from the low five bits of index 0.

Top module: `smb_idx_target`

## Requirements
- R1: The target acknowledges address byte 0xD2 (write) and 0xD3 (read), which is 7-bit address 0x69. Any other address byte is not acknowledged, and SDA is then left released until the next start condition.
- R2: A write transfer is address, index N, count X, then data. The target acknowledges each of these bytes, and data byte k (from 0) lands in index N+k.
- R3: In a write, data bytes after the X-th are not acknowledged and change no register. The target then stays off the bus until the next start.
- R4: A read transfer is address 0xD2, index N, repeated start, address 0xD3. The target then sends the value of index 8 first, followed by the bytes of index N, N+1, and so on, MSB first. It keeps sending while the host acknowledges and releases SDA after a not-acknowledge.
- R5: The index advances by one after every data byte in both directions. Indices 14 and above read as 0x00, and writes to them change nothing, although they are still acknowledged while the count lasts.
- R6: Bits 7:4 of index 5 always hold the revision parameter REV_ID (default 0x1), and index 7 always reads 0xFF. Writes to these bits are ignored.
- R7: After reset the indices 0 to 13 hold 0x00, 0xDB, 0xFF, 0xEF, 0x15, {REV_ID,0xD}, 0xFF, 0xFF, 0x0F, 0x07, 0x08, 0x00, 0x00, 0x00. Index 3 is all ones except bit 4.
- R8: `strap_fs` is captured while `rst` is high. `freq_sel` equals bits 4:0 of index 0 when bit 7 of index 0 is 1, and equals the captured strap when that bit is 0. The output is registered and lags one cycle.
- R9: Start and stop are SDA falling and rising edges while SCL is high, seen after a two-flop synchroniser and a FILT_LEN-sample glitch filter. A pulse on either line shorter than FILT_LEN system clocks is ignored. The target changes SDA only while the filtered SCL is low.
- R10: Byte i of the register file appears on `cfg[8*i+7:8*i]`. It changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| strap_fs | input | 5 | Frequency-select strap levels |
| cfg | output | 112 | Register file contents, index i at bits 8i+7:8i |
| freq_sel | output | 5 | Selected frequency code (strap or register) |

## Verification
On every cycle, the bound checker enforces several timing rules. SDA is only taken or released while the filtered SCL is low, and the register bus never moves during an SCL high phase. The read-only revision nibble and index 7 are checked as well, along with the strap-or-register choice made for `freq_sel`. Protocol meaning can only be shown by the bench's transfers, because a property cannot compute it without a reference model. That covers which address and data bytes are acknowledged, the count-first ordering of reads, index advance past the top of the file, bytes beyond the count, and the rejection of a one-cycle glitch that would otherwise look like a start.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } eng_st_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_DATA
  } eng_ph_t;

  localparam int COUNT_IDX = 8;

  function automatic logic [7:0] reg_rst(input int idx, input logic [3:0] rev);
    case (idx)
      0:       return 8'h00;
      1:       return 8'hDB;
      2:       return 8'hFF;
      3:       return 8'hEF;
      4:       return 8'h15;
      5:       return {rev, 4'hD};
      6:       return 8'hFF;
      7:       return 8'hFF;
      8:       return 8'h0F;
      9:       return 8'h07;
      10:      return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_ro(input int idx);
    case (idx)
      5:       return 8'hF0;
      7:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_filt.sv
module smb_filt #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level
);
  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      hist_q <= '1;
      level  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], pin};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      if (&hist_q)       level <= 1'b1;
      else if (~|hist_q) level <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
#(
  parameter int         N_REGS = 14,
  parameter logic [3:0] REV_ID = 4'h1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [7:0]          widx,
  input  logic [7:0]          wdata,
  input  logic [7:0]          rd_idx,
  output logic [7:0]          rd_data,
  output logic [7:0]          count_q,
  output logic [N_REGS*8-1:0] cfg
);
  logic [7:0] regs [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    localparam logic [7:0] RV = reg_rst(g, REV_ID);
    localparam logic [7:0] RO = reg_ro(g);
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= RV;
      else if (we && widx == 8'(g))
        regs[g] <= (regs[g] & RO) | (wdata & ~RO);
    end
    assign cfg[8*g +: 8] = regs[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < N_REGS; k++)
      if (rd_idx == 8'(k)) rd_data = regs[k];
  end

  assign count_q = regs[COUNT_IDX];
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h69
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [7:0] count_q,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       we,
  output logic [7:0] widx,
  output logic [7:0] wdata,
  output logic       sda_oe
);
  eng_st_t    st;
  eng_ph_t    ph;
  logic       scl_q, sda_q;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic [7:0] ptr;
  logic [7:0] remain;
  logic       rd_mode;
  logic       mack;

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire bus_start = scl_f & scl_q & sda_q & ~sda_f;
  wire bus_stop  = scl_f & scl_q & ~sda_q & sda_f;

  assign rd_idx = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ph      <= PH_ADDR;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      sh      <= 8'h00;
      cnt     <= 4'd0;
      ptr     <= 8'h00;
      remain  <= 8'h00;
      rd_mode <= 1'b0;
      mack    <= 1'b0;
      we      <= 1'b0;
      widx    <= 8'h00;
      wdata   <= 8'h00;
      sda_oe  <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      we    <= 1'b0;
      if (bus_start) begin
        st     <= ST_RX;
        ph     <= PH_ADDR;
        cnt    <= 4'd0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              case (ph)
                PH_ADDR: begin
                  if (sh[7:1] == ADDR7) begin
                    rd_mode <= sh[0];
                    ph      <= PH_INDEX;
                    sda_oe  <= 1'b1;
                    st      <= ST_RX_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_INDEX: begin
                  ptr    <= sh;
                  ph     <= PH_COUNT;
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
                PH_COUNT: begin
                  remain <= sh;
                  ph     <= PH_DATA;
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
                default: begin
                  if (remain != 8'h00) begin
                    we     <= 1'b1;
                    widx   <= ptr;
                    wdata  <= sh;
                    ptr    <= ptr + 8'd1;
                    remain <= remain - 8'd1;
                    sda_oe <= 1'b1;
                    st     <= ST_RX_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              cnt <= 4'd0;
              if (rd_mode) begin
                sh     <= count_q;
                sda_oe <= ~count_q[7];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_f;
            end else if (scl_fall) begin
              if (mack) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ptr + 8'd1;
                cnt    <= 4'd0;
                st     <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_idx_target.sv
module smb_idx_target
  import smb_pkg::*;
#(
  parameter int         N_REGS   = 14,
  parameter int         FILT_LEN = 3,
  parameter logic [6:0] ADDR7    = 7'h69,
  parameter logic [3:0] REV_ID   = 4'h1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  input  logic [4:0]          strap_fs,
  output logic [N_REGS*8-1:0] cfg,
  output logic [4:0]          freq_sel
);
  logic       scl_f, sda_f;
  logic [7:0] rd_idx, rd_data, count_q, widx, wdata;
  logic       we;
  logic [4:0] strap_q;

  smb_filt #(.FILT_LEN(FILT_LEN)) u_filt_scl (
    .clk(clk), .rst(rst), .pin(scl_i), .level(scl_f));
  smb_filt #(.FILT_LEN(FILT_LEN)) u_filt_sda (
    .clk(clk), .rst(rst), .pin(sda_i), .level(sda_f));

  smb_engine #(.ADDR7(ADDR7)) u_engine (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .count_q(count_q), .rd_data(rd_data), .rd_idx(rd_idx),
    .we(we), .widx(widx), .wdata(wdata), .sda_oe(sda_oe));

  smb_regfile #(.N_REGS(N_REGS), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst(rst), .we(we), .widx(widx), .wdata(wdata),
    .rd_idx(rd_idx), .rd_data(rd_data), .count_q(count_q), .cfg(cfg));

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q  <= strap_fs;
      freq_sel <= strap_fs;
    end else begin
      freq_sel <= cfg[7] ? cfg[4:0] : strap_q;
    end
  end
endmodule

// File: rtl/smb_idx_target_chk.sv
module smb_idx_target_chk #(
  parameter int         N_REGS = 14,
  parameter logic [3:0] REV_ID = 4'h1
) (
  input logic                clk,
  input logic                rst,
  input logic                scl_f,
  input logic                sda_oe,
  input logic [N_REGS*8-1:0] cfg,
  input logic [4:0]          freq_sel,
  input logic [4:0]          strap_q
);
  p_take_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_f);

  p_sda_hold_high_r9: assert property (@(posedge clk) disable iff (rst)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  p_cfg_hold_high_r10: assert property (@(posedge clk) disable iff (rst)
    (scl_f && $past(scl_f)) |-> $stable(cfg));

  p_ro_bits_r6: assert property (@(posedge clk) disable iff (rst)
    scl_f |-> (cfg[5*8+4 +: 4] == REV_ID && cfg[7*8 +: 8] == 8'hFF));

  p_fsel_src_r8: assert property (@(posedge clk) disable iff (rst)
    !scl_f |=> freq_sel == ($past(cfg[7]) ? $past(cfg[4:0]) : $past(strap_q)));
endmodule

bind smb_idx_target smb_idx_target_chk #(.N_REGS(N_REGS), .REV_ID(REV_ID)) u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_f), .sda_oe(sda_oe),
  .cfg(cfg), .freq_sel(freq_sel), .strap_q(strap_q));

// File: tb/test_smb_idx_target.sv
module test_smb_idx_target;
  localparam int N  = 14;
  localparam int H  = 20;
  localparam int Q  = 4;
  localparam logic [4:0] STRAP = 5'b10110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [N*8-1:0] cfg;
  logic [4:0] freq_sel;
  wire sda_ln = sda_m & ~sda_oe;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] mdl [N];
  logic [7:0] wbuf [16];

  always #2 clk = ~clk;

  smb_idx_target i_smb_idx_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_ln), .sda_oe(sda_oe),
    .strap_fs(STRAP), .cfg(cfg), .freq_sel(freq_sel));

  function automatic logic [7:0] ro_mask(input int i);
    return (i == 5) ? 8'hF0 : (i == 7) ? 8'hFF : 8'h00;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < N; i++) chk(tag, cfg[8*i +: 8], mdl[i]);
  endtask

  task automatic m_start;
    sda_m = 1; scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(Q);
  endtask
  task automatic m_rstart;
    sda_m = 1; tick(H - Q); scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(Q);
  endtask
  task automatic m_stop;
    sda_m = 0; tick(H - Q); scl_m = 1; tick(H); sda_m = 1; tick(H);
  endtask

  task automatic m_send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H - Q); scl_m = 1; tick(H); scl_m = 0; tick(Q);
    end
    sda_m = 1; tick(H - Q); scl_m = 1; tick(H / 2); ack = ~sda_ln;
    tick(H / 2); scl_m = 0; tick(Q);
  endtask

  task automatic m_recv(input logic give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      tick(H - Q); scl_m = 1; tick(H / 2); b = {b[6:0], sda_ln};
      tick(H / 2); scl_m = 0; tick(Q);
    end
    sda_m = ~give_ack; tick(H - Q); scl_m = 1; tick(H); scl_m = 0; tick(Q);
    sda_m = 1;
  endtask

  // Write transfer: count n, nsend data bytes sent; bytes past n must be refused (R3)
  task automatic wr_xfer(input logic [7:0] idx, input int n, input int nsend, input string tag);
    logic a;
    m_start;
    m_send(8'hD2, a); chk({tag, " R1 addr ack"}, {7'd0, a}, 8'd1);
    m_send(idx, a);   chk({tag, " R2 index ack"}, {7'd0, a}, 8'd1);
    m_send(8'(n), a); chk({tag, " R2 count ack"}, {7'd0, a}, 8'd1);
    for (int k = 0; k < nsend; k++) begin
      m_send(wbuf[k], a);
      if (k < n) begin
        chk({tag, " R2 data ack"}, {7'd0, a}, 8'd1);
        if (int'(idx) + k < N)
          mdl[int'(idx) + k] = (mdl[int'(idx) + k] & ro_mask(int'(idx) + k)) |
                               (wbuf[k] & ~ro_mask(int'(idx) + k));
      end else begin
        chk({tag, " R3 extra nack"}, {7'd0, a}, 8'd0);
      end
    end
    m_stop;
    tick(4);
    check_all({tag, " regs"});
  endtask

  task automatic rd_xfer(input logic [7:0] idx, input int n, input string tag);
    logic a;
    logic [7:0] b;
    m_start;
    m_send(8'hD2, a); chk({tag, " R1 addr ack"}, {7'd0, a}, 8'd1);
    m_send(idx, a);   chk({tag, " R4 index ack"}, {7'd0, a}, 8'd1);
    m_rstart;
    m_send(8'hD3, a); chk({tag, " R1 read addr ack"}, {7'd0, a}, 8'd1);
    m_recv(1'b1, b);  chk({tag, " R4 count first"}, b, mdl[8]);
    for (int k = 0; k < n; k++) begin
      m_recv(k < n - 1, b);
      chk({tag, " R4 R5 data"}, b, (int'(idx) + k < N) ? mdl[int'(idx) + k] : 8'h00);
    end
    chk({tag, " R4 released after nack"}, {7'd0, sda_oe}, 8'd0);
    m_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic a;
    // R7 reset values
    mdl[0] = 8'h00; mdl[1] = 8'hDB; mdl[2] = 8'hFF; mdl[3] = 8'hEF;
    mdl[4] = 8'h15; mdl[5] = 8'h1D; mdl[6] = 8'hFF; mdl[7] = 8'hFF;
    mdl[8] = 8'h0F; mdl[9] = 8'h07; mdl[10] = 8'h08;
    mdl[11] = 8'h00; mdl[12] = 8'h00; mdl[13] = 8'h00;
    tick(8);
    rst = 0;
    tick(8);
    check_all("R7 reset");
    chk("R8 strap after reset", {3'd0, freq_sel}, {3'd0, STRAP});
    chk("R1 idle release", {7'd0, sda_oe}, 8'd0);

    // R2 R6 single-byte sweep over every index with two patterns
    for (int i = 0; i < N; i++) begin
      wbuf[0] = 8'hA5; wr_xfer(8'(i), 1, 1, "R2 sweep A5");
      wbuf[0] = 8'h5A; wr_xfer(8'(i), 1, 1, "R6 sweep 5A");
    end

    // R2 R5 full block write, then block read spilling past the top
    for (int k = 0; k < N; k++) wbuf[k] = 8'(k * 29 + 3);
    wr_xfer(8'd0, N, N, "R2 block");
    rd_xfer(8'd0, 16, "R4 block read");
    rd_xfer(8'd12, 3, "R5 read wrap");

    // R5 writes crossing the top are acked but ignored above index 13
    wbuf[0] = 8'h3C; wbuf[1] = 8'h44;
    wr_xfer(8'd13, 2, 2, "R5 top write");
    wr_xfer(8'd14, 2, 2, "R5 beyond write");

    // R3 bytes beyond the count
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_xfer(8'd2, 1, 2, "R3 overcount");

    // R1 wrong address: no ack, stays off the bus
    m_start;
    m_send(8'hA4, a); chk("R1 wrong addr nack", {7'd0, a}, 8'd0);
    m_send(8'h00, a); chk("R1 silent after miss", {7'd0, a}, 8'd0);
    m_stop;
    tick(4);
    check_all("R1 regs untouched");

    // R8 register-sourced frequency select and back to strap
    wbuf[0] = 8'h8B; wr_xfer(8'd0, 1, 1, "R8 reg src");
    chk("R8 freq from reg", {3'd0, freq_sel}, 8'h0B);
    wbuf[0] = 8'h0B; wr_xfer(8'd0, 1, 1, "R8 strap src");
    chk("R8 freq from strap", {3'd0, freq_sel}, {3'd0, STRAP});

    // R9 one-cycle SDA glitch while SCL high is not a start
    sda_m = 0; tick(1); sda_m = 1; tick(H);
    scl_m = 0; tick(Q);
    m_send(8'hD2, a); chk("R9 glitch ignored", {7'd0, a}, 8'd0);
    m_stop;
    tick(4);
    check_all("R9 regs untouched");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule